// File: doc/BRIEF.md
# Link Power Mode Controller

This block picks the power state of one end of a serial video link. It uses two inputs: an active-low shutdown pin and a measurement of the incoming pixel clock. A free-running reference clock times fixed measurement windows. In each window the block counts the rising edges of the pixel clock, after passing that clock through a synchronizer. A pixel clock at 500 kHz or faster counts as running. Anything slower counts as stopped.

There are three states. Shutdown holds every internal datapath register in reset. Standby waits for the pixel clock to start. Active lets the link run. A static mode pin selects the transmitter or the receiver personality. For the transmitter, the block drives the output-enable flags of the serial data lanes and of the serial clock lane. For the receiver, the block either passes the recovered parallel pixel word, the pixel clock and the serial inputs through, or parks them at fixed levels. Outside Active, the serial inputs read as pulled low, and the parallel outputs take their parked levels: colour and sync bits high, data-enable and pixel clock low.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `sd_n` is low, `pwr_state` reads 0 (Shutdown) and `dp_rst_n` reads 0 whatever `pix_clk` does. A falling `sd_n` forces this before the next `ref_clk` edge.
- R2: After `sd_n` rises with `pix_clk` stopped, `dp_rst_n` reads 1 and `pwr_state` reads 1 (Standby) within three `ref_clk` rising edges.
- R3: A window lasts WIN_CYC `ref_clk` cycles. A window is above threshold when it holds at least ceil(500 kHz × WIN_CYC / REF_HZ) pixel-clock rising edges, which is 8 at the defaults. A 250 kHz or 400 kHz pixel clock leaves the state in Standby. A 700 kHz clock brings the state to Active.
- R4: Standby moves to Active (`pwr_state` = 2) only at the end of the second consecutive above-threshold window. After `sd_n` rises with a 1 MHz pixel clock, the state is still Standby 1.5 windows later and is Active 2 windows plus 200 cycles later.
- R5: Active returns to Standby at the end of the first window that is below threshold. Once `pix_clk` stops, Standby is reached within two windows.
- R6: `tx_lane_oe` (all bits) and `tx_clk_oe` are 1 only in Active with `rx_mode` = 0. They are 0 in every other case.
- R7: Unless the state is Active with `rx_mode` = 1, `rx_pix_out` is parked and `rx_pclk_out` is 0. In `rx_pix_out`, the 24 colour bits occupy bits [26:3]. Bit 2 is HS, bit 1 is VS and bit 0 is DE. The parked word has bits [26:1] set to 1 and bit 0 set to 0.
- R8: Unless the state is Active with `rx_mode` = 1, `rx_ser_out` is all zeros, whatever `rx_ser_in` carries.
- R9: In Active with `rx_mode` = 1, `rx_pix_out` equals `rx_pix_in`, `rx_pclk_out` equals `rx_pclk_in` and `rx_ser_out` equals `rx_ser_in`.
- R10: Shutdown clears the detector history. After Shutdown ends, Active again needs two full above-threshold windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| sd_n | input | 1 | Shutdown pin, active low |
| pix_clk | input | 1 | Pixel clock under measurement |
| rx_mode | input | 1 | Static personality select: 0 transmitter, 1 receiver |
| rx_ser_in | input | LANES+1 | Receiver serial inputs: data lanes plus clock lane |
| rx_pix_in | input | 3*COLOR_W+3 | Recovered parallel pixel word |
| rx_pclk_in | input | 1 | Recovered pixel clock |
| pwr_state | output | 2 | 0 Shutdown, 1 Standby, 2 Active |
| dp_rst_n | output | 1 | Datapath reset, active low |
| tx_lane_oe | output | LANES | Output enables for the transmitter serial data lanes |
| tx_clk_oe | output | 1 | Output enable for the transmitter serial clock lane |
| rx_ser_out | output | LANES+1 | Gated serial inputs |
| rx_pix_out | output | 3*COLOR_W+3 | Parallel pixel word, passed through or parked |
| rx_pclk_out | output | 1 | Parallel pixel clock, passed through or parked low |

## Verification
The hardest case to reach from the ports is the exact two-window entry into Active. Window phase is hidden, so the bench aligns it through a known event. It releases `sd_n` with a 1 MHz clock already running, which starts the first window two cycles later. It then samples once between the two window ends and once after the second. The asynchronous path is checked by lowering `sd_n` half a cycle before a `ref_clk` edge and sampling before that edge arrives. The threshold is probed with clocks at 250, 400 and 700 kHz, which straddle the 500 kHz limit.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;

  typedef enum logic [1:0] {
    PWR_SHUTDOWN = 2'd0,
    PWR_STANDBY  = 2'd1,
    PWR_ACTIVE   = 2'd2
  } pwr_e;

  // Minimum number of rising edges per window for a clock at thr_hz or above.
  function automatic int unsigned edge_threshold(longint unsigned ref_hz,
                                                 longint unsigned win_cyc,
                                                 longint unsigned thr_hz);
    longint unsigned t;
    t = (thr_hz * win_cyc + ref_hz - 64'd1) / ref_hz;
    if (t == 64'd0) t = 64'd1;
    return t[31:0];
  endfunction

  // True when the running count plus this cycle's edge meets the threshold.
  function automatic logic count_reached(logic [31:0] cnt, logic rise_now,
                                         int unsigned th);
    return (cnt + {31'd0, rise_now}) >= th;
  endfunction

  // Parked receiver word: colour, HS and VS high; DE (bit 0) low.
  function automatic logic [63:0] parked_word(int unsigned width);
    logic [63:0] w;
    w = '0;
    for (int i = 1; i < 64; i++) begin
      if (i < int'(width)) w[i] = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/lpc_sd_sync.sv
`timescale 1ns/1ps
module lpc_sd_sync (
  input  logic clk,
  input  logic sd_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  // Assertion of sd_n clears immediately; release goes through two flops.
  always_ff @(posedge clk or negedge sd_n) begin
    if (!sd_n) stage_q <= 2'b00;
    else       stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/lpc_clk_det.sv
`timescale 1ns/1ps
module lpc_clk_det
  import lpc_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4000,
  parameter int unsigned TH      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_clk,
  output logic win_done,
  output logic win_above
);
  localparam int unsigned WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int unsigned CW = $clog2(TH + 1);

  logic [2:0]    pix_s_q;
  logic [WW-1:0] win_cnt_q;
  logic [CW-1:0] rise_cnt_q;
  logic          done_q, above_q;

  logic rise_seen;
  logic win_end;
  logic hit;

  assign rise_seen = pix_s_q[1] & ~pix_s_q[2];
  assign win_end   = (win_cnt_q == WW'(WIN_CYC - 1));
  assign hit       = count_reached(32'(rise_cnt_q), rise_seen, TH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_s_q <= 3'b000;
    else        pix_s_q <= {pix_s_q[1:0], pix_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt_q  <= '0;
      rise_cnt_q <= '0;
      done_q     <= 1'b0;
      above_q    <= 1'b0;
    end else begin
      done_q <= win_end;
      if (win_end) begin
        win_cnt_q  <= '0;
        rise_cnt_q <= '0;
        above_q    <= hit;
      end else begin
        win_cnt_q <= win_cnt_q + 1'b1;
        if (rise_seen && (rise_cnt_q != CW'(TH)))
          rise_cnt_q <= rise_cnt_q + 1'b1;
      end
    end
  end

  assign win_done  = done_q;
  assign win_above = above_q;

  // R3
  above_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_done |-> $stable(win_above));

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rise_cnt_q) <= TH);
endmodule

// File: rtl/lpc_state.sv
`timescale 1ns/1ps
module lpc_state
  import lpc_pkg::*;
#(
  parameter int unsigned ENTER_WINS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_done,
  input  logic win_above,
  output pwr_e state
);
  localparam int unsigned SW = $clog2(ENTER_WINS + 1);

  pwr_e          state_q;
  logic [SW-1:0] streak_q;

  logic enter_ok;
  logic leave_now;
  logic is_active;

  assign enter_ok  = win_done && win_above && (32'(streak_q) + 32'd1 >= ENTER_WINS);
  assign leave_now = win_done && !win_above;
  assign is_active = (state_q == PWR_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PWR_SHUTDOWN;
      streak_q <= '0;
    end else begin
      unique case (state_q)
        PWR_SHUTDOWN: state_q <= PWR_STANDBY;
        PWR_STANDBY: begin
          if (enter_ok) begin
            state_q  <= PWR_ACTIVE;
            streak_q <= '0;
          end else if (win_done) begin
            streak_q <= win_above ? streak_q + 1'b1 : '0;
          end
        end
        PWR_ACTIVE: begin
          if (leave_now) state_q <= PWR_STANDBY;
        end
        default: state_q <= PWR_STANDBY;
      endcase
    end
  end

  assign state = state_q;

  // R2
  no_shutdown_when_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> state_q != PWR_SHUTDOWN);

  // R4
  enter_on_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_active) |-> ($past(win_done) && $past(win_above)));

  // R5
  leave_one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active && win_done && !win_above) |=> state_q == PWR_STANDBY);
endmodule

// File: rtl/lpc_out_force.sv
`timescale 1ns/1ps
module lpc_out_force
  import lpc_pkg::*;
#(
  parameter int unsigned LANES = 3,
  parameter int unsigned PIX_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwr_e             state,
  input  logic             rx_mode,
  input  logic [LANES:0]   rx_ser_in,
  input  logic [PIX_W-1:0] rx_pix_in,
  input  logic             rx_pclk_in,
  output logic [LANES-1:0] tx_lane_oe,
  output logic             tx_clk_oe,
  output logic [LANES:0]   rx_ser_out,
  output logic [PIX_W-1:0] rx_pix_out,
  output logic             rx_pclk_out
);
  localparam logic [63:0]      PARK64 = parked_word(PIX_W);
  localparam logic [PIX_W-1:0] PARK   = PARK64[PIX_W-1:0];

  logic tx_live;
  logic rx_live;

  assign tx_live = (state == PWR_ACTIVE) && !rx_mode;
  assign rx_live = (state == PWR_ACTIVE) &&  rx_mode;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane_oe
    assign tx_lane_oe[g] = tx_live;
  end
  assign tx_clk_oe = tx_live;

  for (genvar s = 0; s <= int'(LANES); s++) begin : g_ser_gate
    assign rx_ser_out[s] = rx_live & rx_ser_in[s];
  end

  assign rx_pix_out  = rx_live ? rx_pix_in : PARK;
  assign rx_pclk_out = rx_live & rx_pclk_in;

  // R6
  tx_oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clk_oe || (|tx_lane_oe)) |-> (state == PWR_ACTIVE && !rx_mode));

  // R7
  parked_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PWR_ACTIVE) |-> (!rx_pix_out[0] && !rx_pclk_out));

  // R8
  parked_ser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PWR_ACTIVE) |-> ($countones(rx_ser_out) == 0));
endmodule

// File: rtl/link_pwr_ctrl.sv
`timescale 1ns/1ps
module link_pwr_ctrl
  import lpc_pkg::*;
#(
  parameter longint unsigned REF_HZ     = 250_000_000,
  parameter int unsigned     WIN_CYC    = 4000,
  parameter longint unsigned THRESH_HZ  = 500_000,
  parameter int unsigned     ENTER_WINS = 2,
  parameter int unsigned     LANES      = 3,
  parameter int unsigned     COLOR_W    = 8
) (
  input  logic                   ref_clk,
  input  logic                   sd_n,
  input  logic                   pix_clk,
  input  logic                   rx_mode,
  input  logic [LANES:0]         rx_ser_in,
  input  logic [3*COLOR_W+2:0]   rx_pix_in,
  input  logic                   rx_pclk_in,
  output logic [1:0]             pwr_state,
  output logic                   dp_rst_n,
  output logic [LANES-1:0]       tx_lane_oe,
  output logic                   tx_clk_oe,
  output logic [LANES:0]         rx_ser_out,
  output logic [3*COLOR_W+2:0]   rx_pix_out,
  output logic                   rx_pclk_out
);
  localparam int unsigned PIX_W = 3 * COLOR_W + 3;
  localparam int unsigned TH    = edge_threshold(REF_HZ, 64'(WIN_CYC), THRESH_HZ);

  logic rst_n;
  logic win_done;
  logic win_above;
  pwr_e state;

  lpc_sd_sync i_sd_sync (
    .clk   (ref_clk),
    .sd_n  (sd_n),
    .rst_n (rst_n)
  );

  lpc_clk_det #(.WIN_CYC(WIN_CYC), .TH(TH)) i_clk_det (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .pix_clk   (pix_clk),
    .win_done  (win_done),
    .win_above (win_above)
  );

  lpc_state #(.ENTER_WINS(ENTER_WINS)) i_state (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .win_done  (win_done),
    .win_above (win_above),
    .state     (state)
  );

  lpc_out_force #(.LANES(LANES), .PIX_W(PIX_W)) i_out_force (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .state       (state),
    .rx_mode     (rx_mode),
    .rx_ser_in   (rx_ser_in),
    .rx_pix_in   (rx_pix_in),
    .rx_pclk_in  (rx_pclk_in),
    .tx_lane_oe  (tx_lane_oe),
    .tx_clk_oe   (tx_clk_oe),
    .rx_ser_out  (rx_ser_out),
    .rx_pix_out  (rx_pix_out),
    .rx_pclk_out (rx_pclk_out)
  );

  assign pwr_state = state;
  assign dp_rst_n  = rst_n;

  // R1
  shutdown_state_chk: assert property (@(posedge ref_clk) disable iff (!sd_n)
    !dp_rst_n |-> pwr_state == PWR_SHUTDOWN);
endmodule

// File: tb/test_link_pwr_ctrl.sv
`timescale 1ns/1ps
module test_link_pwr_ctrl;
  localparam int WIN = 4000;

  logic        ref_clk = 1'b0;
  logic        sd_n = 1'b0;
  logic        pix_clk = 1'b0;
  logic        rx_mode = 1'b0;
  logic [3:0]  rx_ser_in = 4'h0;
  logic [26:0] rx_pix_in = '0;
  logic        rx_pclk_in = 1'b0;
  logic [1:0]  pwr_state;
  logic        dp_rst_n;
  logic [2:0]  tx_lane_oe;
  logic        tx_clk_oe;
  logic [3:0]  rx_ser_out;
  logic [26:0] rx_pix_out;
  logic        rx_pclk_out;

  int total = 0;
  int bad = 0;
  int pix_half = 500;
  bit pix_run = 1'b1;

  localparam logic [26:0] PARKED = {26'h3FFFFFF, 1'b0};

  link_pwr_ctrl i_link_pwr_ctrl (
    .ref_clk(ref_clk), .sd_n(sd_n), .pix_clk(pix_clk), .rx_mode(rx_mode),
    .rx_ser_in(rx_ser_in), .rx_pix_in(rx_pix_in), .rx_pclk_in(rx_pclk_in),
    .pwr_state(pwr_state), .dp_rst_n(dp_rst_n), .tx_lane_oe(tx_lane_oe),
    .tx_clk_oe(tx_clk_oe), .rx_ser_out(rx_ser_out), .rx_pix_out(rx_pix_out),
    .rx_pclk_out(rx_pclk_out)
  );

  always #2 ref_clk = ~ref_clk;

  always begin
    if (pix_run) begin
      #(pix_half) pix_clk = ~pix_clk;
    end else begin
      pix_clk = 1'b0;
      #4;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic t_reset_state;
    cyc(20);
    check("R1 state", 64'(pwr_state), 64'd0);
    check("R1 dp_rst_n", 64'(dp_rst_n), 64'd0);
    check("R6 lane oe", 64'({tx_clk_oe, tx_lane_oe}), 64'd0);
    check("R7 pix parked", 64'(rx_pix_out), 64'(PARKED));
  endtask

  task automatic t_wake_standby;
    pix_run = 1'b0;
    cyc(2);
    sd_n = 1'b1;
    rx_pix_in = 27'h1234567; rx_ser_in = 4'hF; rx_pclk_in = 1'b1;
    cyc(5);
    check("R2 state", 64'(pwr_state), 64'd1);
    check("R2 dp_rst_n", 64'(dp_rst_n), 64'd1);
    check("R7 pix parked", 64'(rx_pix_out), 64'(PARKED));
    check("R7 pclk low", 64'(rx_pclk_out), 64'd0);
    check("R8 ser parked", 64'(rx_ser_out), 64'd0);
  endtask

  task automatic t_threshold;
    pix_half = 2000; pix_run = 1'b1;
    cyc(3 * WIN + 500);
    check("R3 250k standby", 64'(pwr_state), 64'd1);
    pix_half = 1250;
    cyc(3 * WIN + 500);
    check("R3 400k standby", 64'(pwr_state), 64'd1);
    pix_half = 714;
    cyc(3 * WIN + 300);
    check("R3 700k active", 64'(pwr_state), 64'd2);
    check("R6 tx oe on", 64'({tx_clk_oe, tx_lane_oe}), 64'hF);
    check("R7 tx personality parked", 64'(rx_pix_out), 64'(PARKED));
  endtask

  task automatic t_leave;
    pix_run = 1'b0;
    cyc(100);
    check("R5 still active", 64'(pwr_state), 64'd2);
    cyc(2 * WIN);
    check("R5 standby", 64'(pwr_state), 64'd1);
    check("R6 tx oe off", 64'({tx_clk_oe, tx_lane_oe}), 64'd0);
  endtask

  task automatic t_async_shutdown;
    pix_half = 500; pix_run = 1'b1;
    cyc(3 * WIN + 300);
    check("R4 active again", 64'(pwr_state), 64'd2);
    sd_n = 1'b0;
    #1;
    check("R1 async state", 64'(pwr_state), 64'd0);
    check("R1 async dp_rst_n", 64'(dp_rst_n), 64'd0);
    check("R6 async oe", 64'({tx_clk_oe, tx_lane_oe}), 64'd0);
    cyc(10);
  endtask

  task automatic t_rx_entry;
    rx_mode = 1'b1;
    cyc(5);
    sd_n = 1'b1;
    cyc(WIN + WIN / 2);
    check("R4 R10 one window not enough", 64'(pwr_state), 64'd1);
    cyc(WIN / 2 + 200);
    check("R4 two windows active", 64'(pwr_state), 64'd2);
    check("R6 rx no tx oe", 64'({tx_clk_oe, tx_lane_oe}), 64'd0);
    rx_pix_in = 27'h5A5A5A1; rx_ser_in = 4'hA; rx_pclk_in = 1'b1;
    #1;
    check("R9 pix pass", 64'(rx_pix_out), 64'h5A5A5A1);
    check("R9 ser pass", 64'(rx_ser_out), 64'hA);
    check("R9 pclk pass", 64'(rx_pclk_out), 64'd1);
    rx_pclk_in = 1'b0; rx_ser_in = 4'h5;
    #1;
    check("R9 pclk low pass", 64'(rx_pclk_out), 64'd0);
    check("R9 ser pass 2", 64'(rx_ser_out), 64'h5);
  endtask

  task automatic t_rx_leave;
    pix_run = 1'b0;
    rx_ser_in = 4'hF; rx_pclk_in = 1'b1;
    cyc(2 * WIN + 100);
    check("R5 rx standby", 64'(pwr_state), 64'd1);
    check("R7 rx pix parked", 64'(rx_pix_out), 64'(PARKED));
    check("R7 rx pclk low", 64'(rx_pclk_out), 64'd0);
    check("R8 rx ser parked", 64'(rx_ser_out), 64'd0);
  endtask

  initial begin
    t_reset_state();
    t_wake_standby();
    t_threshold();
    t_leave();
    t_async_shutdown();
    t_rx_entry();
    t_rx_leave();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #760000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule